// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a single shift register of recent branch outcomes. Every branch feeds this register, whatever its address. It also keeps one table of two-bit saturating counters. To look up a prediction, the block merges the history with low bits of the branch address into a table index and reads that one counter. The prediction is the upper bit of the counter. A build-time parameter picks how the merge is done. In XOR mode, address bits are XORed with the full history. In concatenate mode, a shorter history sits above a few address bits.

The fetch side raises a lookup strobe with the branch address. One cycle later it gets back the prediction together with the index that was used. It keeps that index alongside the branch. When the branch resolves, the index and the real outcome are sent back on the resolve port. The counter at that index is trained, and the outcome is shifted into the history. The history is only advanced at resolve time. Nothing is speculatively updated, so no recovery is needed.

The reset input is asynchronous and active low. It is expected to be released synchronously to the clock.

Top module: `gsel_predictor`

## Requirements
- R1: While reset is asserted and right after it, the history is all zeros, every counter is weakly not taken (2'b01), and pred_valid is low, so the first lookup of any address predicts not taken.
- R2: pred_valid is high in exactly the cycle after a cycle with lookup_valid high, and low otherwise.
- R3: In XOR mode (MODE = IDX_SHARE), pred_index equals lookup_addr[11:2] XOR the 10-bit history, as the history stood in the lookup cycle.
- R4: In concatenate mode (MODE = IDX_SELECT), pred_index equals {history[5:0], lookup_addr[5:2]}, with the history in the upper six bits and the history as it stood in the lookup cycle.
- R5: A resolve with resolve_taken = 1 increments the addressed counter, and the counter stays at 2'b11 once it reaches it.
- R6: A resolve with resolve_taken = 0 decrements the addressed counter, and the counter stays at 2'b00 once it reaches it.
- R7: Training writes the counter at resolve_index as supplied. The index is not recomputed from the current history.
- R8: Each resolve shifts resolve_taken into history bit 0, moving older bits toward the MSB. Cycles without a resolve leave the history unchanged.
- R9: When a lookup and a resolve fall in the same cycle, the lookup uses the counter and history values from before that resolve.
- R10: pred_taken is bit 1 of the selected counter, so 2'b10 and 2'b11 predict taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lookup_valid | input | 1 | Lookup request strobe |
| lookup_addr | input | ADDR_W | Branch address to predict |
| resolve_valid | input | 1 | Resolved-branch strobe |
| resolve_taken | input | 1 | Actual outcome, 1 = taken |
| resolve_index | input | IDX_W | Index returned with the prediction for this branch |
| pred_valid | output | 1 | Prediction valid, one cycle after the lookup |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_index | output | IDX_W | Counter index used for this prediction |

## Verification
The bench drives a counter past 2'b11 and below 2'b00 and then looks it up. A design that wraps instead of saturating would flip the prediction after a single opposite outcome. A lookup and a resolve of the same index are issued together. A design that bypasses the write would report the new counter, or hash with the already-shifted history. Hand-computed indices in both modes catch a design with swapped concatenation order, a shift into the wrong end of the history, or training through a recomputed index rather than the returned one. A second reset in the middle of the run catches a design whose counters are not reset to weakly not taken.

// File: rtl/gp_pkg.sv
package gp_pkg;

  typedef enum logic {
    IDX_SHARE  = 1'b0,
    IDX_SELECT = 1'b1
  } idx_mode_e;

  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_SNT = 2'b00;
  localparam ctr2_t CTR_WNT = 2'b01;
  localparam ctr2_t CTR_WT  = 2'b10;
  localparam ctr2_t CTR_ST  = 2'b11;

  // Two-bit saturating step toward the observed outcome.
  function automatic ctr2_t ctr_step(input ctr2_t cur, input logic taken);
    ctr2_t nxt;
    nxt = cur;
    if (taken) begin
      if (cur != CTR_ST) nxt = cur + 2'b01;
    end else begin
      if (cur != CTR_SNT) nxt = cur - 2'b01;
    end
    return nxt;
  endfunction

endpackage

// File: rtl/gp_hist_reg.sv
module gp_hist_reg #(
  parameter int HIST_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              bit_in,
  output logic [HIST_W-1:0] hist_o
);

  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_d;

  generate
    if (HIST_W > 1) begin : g_wide
      always_comb begin
        hist_d = hist_q;
        if (shift_en) hist_d = {hist_q[HIST_W-2:0], bit_in};
      end
    end else begin : g_single
      always_comb begin
        hist_d = hist_q;
        if (shift_en) hist_d = bit_in;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  assign hist_o = hist_q;

endmodule

// File: rtl/gp_index_gen.sv
module gp_index_gen
  import gp_pkg::*;
#(
  parameter int        ADDR_W  = 32,
  parameter int        IDX_W   = 10,
  parameter int        ADDR_LO = 2,
  parameter int        HIST_W  = 10,
  parameter idx_mode_e MODE    = IDX_SHARE
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [HIST_W-1:0] hist,
  output logic [IDX_W-1:0]  idx
);

  localparam int SEL_ADDR_W = IDX_W - HIST_W;

  generate
    if (MODE == IDX_SHARE) begin : g_share
      localparam int HI = ADDR_LO + IDX_W;
      logic unused_addr_bits;
      assign unused_addr_bits = ^{addr[ADDR_W-1:HI], addr[ADDR_LO-1:0]};
      assign idx = addr[HI-1:ADDR_LO] ^ IDX_W'(hist);
    end else begin : g_select
      localparam int HI = ADDR_LO + SEL_ADDR_W;
      logic unused_addr_bits;
      assign unused_addr_bits = ^{addr[ADDR_W-1:HI], addr[ADDR_LO-1:0]};
      assign idx = {hist, addr[HI-1:ADDR_LO]};
    end
  endgenerate

endmodule

// File: rtl/gp_ctr_table.sv
module gp_ctr_table
  import gp_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr2_t            rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  localparam int DEPTH = 1 << IDX_W;

  ctr2_t ctr_q [DEPTH];
  ctr2_t ctr_d [DEPTH];
  ctr2_t rd_q;
  ctr2_t rd_d;

  // Next state of the counter array: one write port.
  always_comb begin
    for (int i = 0; i < DEPTH; i++) ctr_d[i] = ctr_q[i];
    if (wr_en) ctr_d[wr_idx] = ctr_step(ctr_q[wr_idx], wr_taken);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_WNT;
    end else begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= ctr_d[i];
    end
  end

  // Registered read of the pre-write array contents.
  always_comb begin
    rd_d = rd_q;
    if (rd_en) rd_d = ctr_q[rd_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= CTR_WNT;
    else        rd_q <= rd_d;
  end

  assign rd_ctr = rd_q;

endmodule

// File: rtl/gsel_predictor.sv
module gsel_predictor
  import gp_pkg::*;
#(
  parameter int        ADDR_W     = 32,
  parameter int        IDX_W      = 10,
  parameter int        ADDR_LO    = 2,
  parameter int        SEL_HIST_W = 6,
  parameter idx_mode_e MODE       = IDX_SHARE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lookup_valid,
  input  logic [ADDR_W-1:0] lookup_addr,
  input  logic              resolve_valid,
  input  logic              resolve_taken,
  input  logic [IDX_W-1:0]  resolve_index,
  output logic              pred_valid,
  output logic              pred_taken,
  output logic [IDX_W-1:0]  pred_index
);

  localparam int HIST_W = (MODE == IDX_SHARE) ? IDX_W : SEL_HIST_W;

  logic [HIST_W-1:0] hist_q;
  logic [IDX_W-1:0]  lk_idx;
  ctr2_t             rd_ctr;

  logic              pv_q, pv_d;
  logic [IDX_W-1:0]  pidx_q, pidx_d;

  gp_hist_reg #(.HIST_W(HIST_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (resolve_valid),
    .bit_in   (resolve_taken),
    .hist_o   (hist_q)
  );

  gp_index_gen #(
    .ADDR_W  (ADDR_W),
    .IDX_W   (IDX_W),
    .ADDR_LO (ADDR_LO),
    .HIST_W  (HIST_W),
    .MODE    (MODE)
  ) u_idx (
    .addr (lookup_addr),
    .hist (hist_q),
    .idx  (lk_idx)
  );

  gp_ctr_table #(.IDX_W(IDX_W)) u_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (lookup_valid),
    .rd_idx   (lk_idx),
    .rd_ctr   (rd_ctr),
    .wr_en    (resolve_valid),
    .wr_idx   (resolve_index),
    .wr_taken (resolve_taken)
  );

  always_comb begin
    pv_d   = lookup_valid;
    pidx_d = pidx_q;
    if (lookup_valid) pidx_d = lk_idx;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv_q   <= 1'b0;
      pidx_q <= '0;
    end else begin
      pv_q   <= pv_d;
      pidx_q <= pidx_d;
    end
  end

  assign pred_valid = pv_q;
  assign pred_taken = rd_ctr[1];
  assign pred_index = pidx_q;

endmodule

// File: rtl/gsel_predictor_chk.sv
module gsel_predictor_chk #(
  parameter int IDX_W  = 10,
  parameter int HIST_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lookup_valid,
  input logic              resolve_valid,
  input logic              resolve_taken,
  input logic              pred_valid,
  input logic [IDX_W-1:0]  pred_index,
  input logic [IDX_W-1:0]  lk_idx,
  input logic [HIST_W-1:0] hist
);

  // R1: history and valid are cleared while reset is held.
  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (hist == '0 && !pred_valid)
        else $error("history or valid not cleared in reset");
    end
  end

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_valid |=> pred_valid);

  p_valid_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lookup_valid |=> !pred_valid);

  p_index_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_valid |=> pred_index == $past(lk_idx));

  generate
    if (HIST_W > 1) begin : g_shift_chk
      p_hist_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
        resolve_valid |=> hist == {$past(hist[HIST_W-2:0]), $past(resolve_taken)});
    end
  endgenerate

  p_hist_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !resolve_valid |=> $stable(hist));

endmodule

bind gsel_predictor gsel_predictor_chk #(.IDX_W(IDX_W), .HIST_W(HIST_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .lookup_valid  (lookup_valid),
  .resolve_valid (resolve_valid),
  .resolve_taken (resolve_taken),
  .pred_valid    (pred_valid),
  .pred_index    (pred_index),
  .lk_idx        (lk_idx),
  .hist          (hist_q)
);

// File: tb/gsel_predictor_tb_top.sv
module gsel_predictor_tb_top;

  logic clk;
  logic rst_n;

  logic        a_lk_v, a_rs_v, a_rs_t, a_pr_v, a_pr_t;
  logic [31:0] a_lk_addr;
  logic [9:0]  a_rs_idx, a_pr_idx;
  logic        b_lk_v, b_rs_v, b_rs_t, b_pr_v, b_pr_t;
  logic [31:0] b_lk_addr;
  logic [9:0]  b_rs_idx, b_pr_idx;

  int errs = 0;
  int checks = 0;

  // Reference state built from the requirements.
  logic [1:0] m_ctr [2][1024];
  logic [9:0] m_hist [2];
  logic [9:0] last_idx [2];

  gsel_predictor dut_i (
    .clk(clk), .rst_n(rst_n),
    .lookup_valid(a_lk_v), .lookup_addr(a_lk_addr),
    .resolve_valid(a_rs_v), .resolve_taken(a_rs_t), .resolve_index(a_rs_idx),
    .pred_valid(a_pr_v), .pred_taken(a_pr_t), .pred_index(a_pr_idx)
  );

  gsel_predictor #(.MODE(gp_pkg::IDX_SELECT)) dut_sel_i (
    .clk(clk), .rst_n(rst_n),
    .lookup_valid(b_lk_v), .lookup_addr(b_lk_addr),
    .resolve_valid(b_rs_v), .resolve_taken(b_rs_t), .resolve_index(b_rs_idx),
    .pred_valid(b_pr_v), .pred_taken(b_pr_t), .pred_index(b_pr_idx)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // [18] lookup, [17] resolve, [16] outcome, [15:0] address
  localparam logic [18:0] VEC [16] = '{
    {1'b1, 1'b0, 1'b0, 16'h1000},
    {1'b0, 1'b1, 1'b1, 16'h0000},
    {1'b1, 1'b1, 1'b1, 16'h1004},
    {1'b1, 1'b1, 1'b1, 16'h1004},
    {1'b1, 1'b1, 1'b1, 16'h1004},
    {1'b1, 1'b0, 1'b0, 16'h2468},
    {1'b0, 1'b1, 1'b0, 16'h0000},
    {1'b1, 1'b1, 1'b0, 16'h13FC},
    {1'b1, 1'b1, 1'b1, 16'hFFFC},
    {1'b1, 1'b0, 1'b0, 16'h0040},
    {1'b0, 1'b1, 1'b1, 16'h0000},
    {1'b1, 1'b1, 1'b1, 16'h0040},
    {1'b1, 1'b1, 1'b0, 16'h0ABC},
    {1'b1, 1'b0, 1'b0, 16'h0ABC},
    {1'b1, 1'b1, 1'b1, 16'h5554},
    {1'b1, 1'b1, 1'b1, 16'hAAA8}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int d = 0; d < 2; d++) begin
      for (int i = 0; i < 1024; i++) m_ctr[d][i] = 2'b01;
      m_hist[d] = '0;
      last_idx[d] = '0;
    end
  endtask

  function automatic logic [9:0] m_index(input int d, input logic [31:0] addr);
    if (d == 0) return addr[11:2] ^ m_hist[0];
    return {m_hist[1][5:0], addr[5:2]};
  endfunction

  function automatic logic [31:0] addr_for(input logic [9:0] idx);
    return {20'b0, idx ^ m_hist[0], 2'b00};
  endfunction

  function automatic logic [1:0] m_step(input logic [1:0] c, input logic t);
    if (t)  return (c == 2'b11) ? 2'b11 : c + 2'b01;
    return (c == 2'b00) ? 2'b00 : c - 2'b01;
  endfunction

  // Called at a negative edge; returns at the next negative edge after checking.
  task automatic step(input int d, input bit lk, input logic [31:0] addr,
                      input bit rs, input bit tk, input logic [9:0] ridx, input string tag);
    logic [9:0] e_idx;
    logic       e_pred;
    a_lk_v = (d == 0) && lk; a_lk_addr = addr; a_rs_v = (d == 0) && rs;
    a_rs_t = tk; a_rs_idx = ridx;
    b_lk_v = (d == 1) && lk; b_lk_addr = addr; b_rs_v = (d == 1) && rs;
    b_rs_t = tk; b_rs_idx = ridx;
    e_idx  = m_index(d, addr);
    e_pred = m_ctr[d][e_idx][1];
    if (rs) begin
      m_ctr[d][ridx] = m_step(m_ctr[d][ridx], tk);
      if (d == 0) m_hist[0] = {m_hist[0][8:0], tk};
      else        m_hist[1] = {4'b0, m_hist[1][4:0], tk};
    end
    if (lk) last_idx[d] = e_idx;
    @(posedge clk);
    @(negedge clk);
    a_lk_v = 1'b0; a_rs_v = 1'b0; b_lk_v = 1'b0; b_rs_v = 1'b0;
    if (d == 0) begin
      chk({tag, " R2 valid"}, a_pr_v, lk);
      if (lk) begin
        chk({tag, " index"}, a_pr_idx, e_idx);
        chk({tag, " R10 prediction"}, a_pr_t, e_pred);
      end
    end else begin
      chk({tag, " R2 valid"}, b_pr_v, lk);
      if (lk) begin
        chk({tag, " index"}, b_pr_idx, e_idx);
        chk({tag, " R10 prediction"}, b_pr_t, e_pred);
      end
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
  end

  initial begin
    logic [9:0] x_idx, y_idx, first_idx;
    rst_n = 1'b0;
    a_lk_v = 0; a_lk_addr = '0; a_rs_v = 0; a_rs_t = 0; a_rs_idx = '0;
    b_lk_v = 0; b_lk_addr = '0; b_rs_v = 0; b_rs_t = 0; b_rs_idx = '0;
    model_reset();
    repeat (3) @(negedge clk);
    chk("R1 valid low in reset (share)", a_pr_v, 1'b0);
    chk("R1 valid low in reset (select)", b_pr_v, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 and R3: fresh state predicts not taken, index is the raw address bits.
    step(0, 1, 32'h0000_03FC, 0, 0, '0, "R1 first lookup");
    chk("R3 zero history index", a_pr_idx, 10'h0FF);
    chk("R1 weakly not taken", a_pr_t, 1'b0);

    // R3 hand value: history 110 after outcomes 1,1,0.
    step(0, 0, '0, 1, 1, 10'h001, "R8 shift");
    step(0, 0, '0, 1, 1, 10'h002, "R8 shift");
    step(0, 0, '0, 1, 0, 10'h003, "R8 shift");
    step(0, 1, 32'h0000_0A5C, 0, 0, '0, "R3 xor lookup");
    chk("R3 hand index", a_pr_idx, 10'h291);

    // Vector table on both modes.
    for (int d = 0; d < 2; d++) begin
      for (int v = 0; v < 16; v++) begin
        step(d, VEC[v][18], {16'b0, VEC[v][15:0]}, VEC[v][17], VEC[v][16],
             last_idx[d], (d == 0) ? "R3 R5 R6 R8 vector" : "R4 R5 R6 R8 vector");
      end
    end

    // R4 hand value: history 101101 above address bits 1001.
    step(1, 0, '0, 1, 1, 10'h010, "R8 shift sel");
    step(1, 0, '0, 1, 0, 10'h011, "R8 shift sel");
    step(1, 0, '0, 1, 1, 10'h012, "R8 shift sel");
    step(1, 0, '0, 1, 1, 10'h013, "R8 shift sel");
    step(1, 0, '0, 1, 0, 10'h014, "R8 shift sel");
    step(1, 0, '0, 1, 1, 10'h015, "R8 shift sel");
    step(1, 1, 32'h0000_0024, 0, 0, '0, "R4 concat lookup");
    chk("R4 hand index", b_pr_idx, 10'b1011011001);

    // R5 and R7: saturate high at index x via the returned index.
    x_idx = 10'h155;
    repeat (4) step(0, 0, '0, 1, 1, x_idx, "R7 train");
    step(0, 1, addr_for(x_idx), 0, 0, '0, "R5 R7 saturated high");
    chk("R5 saturated taken", a_pr_t, 1'b1);
    step(0, 0, '0, 1, 0, x_idx, "R5 one down");
    step(0, 1, addr_for(x_idx), 0, 0, '0, "R5 one below top");
    chk("R5 still taken after one miss", a_pr_t, 1'b1);

    // R6: drive below the floor, then check it did not wrap.
    repeat (4) step(0, 0, '0, 1, 0, x_idx, "R6 train");
    step(0, 1, addr_for(x_idx), 0, 0, '0, "R6 floor");
    chk("R6 floor not taken", a_pr_t, 1'b0);
    step(0, 0, '0, 1, 1, x_idx, "R6 up one");
    step(0, 0, '0, 1, 1, x_idx, "R6 up two");
    step(0, 1, addr_for(x_idx), 0, 0, '0, "R6 climb from floor");
    chk("R6 00 plus two is taken", a_pr_t, 1'b1);

    // R9: same-cycle lookup and resolve of one index.
    y_idx = 10'h0F0;
    step(0, 0, '0, 1, 0, y_idx, "R9 prep");
    step(0, 0, '0, 1, 1, y_idx, "R9 prep");
    step(0, 1, addr_for(y_idx), 1, 1, y_idx, "R9 same cycle");
    chk("R9 sees old counter", a_pr_t, 1'b0);
    step(0, 1, addr_for(y_idx), 0, 0, '0, "R9 after update");
    chk("R9 update visible next", a_pr_t, 1'b1);

    // R8: lookups alone leave the history untouched.
    step(0, 1, 32'h0000_777C, 0, 0, '0, "R8 hold first");
    first_idx = a_pr_idx;
    step(0, 0, '0, 0, 0, '0, "R2 idle");
    step(0, 1, 32'h0000_777C, 0, 0, '0, "R8 hold second");
    chk("R8 history unchanged by lookups", a_pr_idx, first_idx);

    // R1: reset in mid-run restores counters and history.
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 valid low in second reset", a_pr_v, 1'b0);
    rst_n = 1'b1;
    model_reset();
    step(0, 1, {20'b0, x_idx, 2'b00}, 0, 0, '0, "R1 after reset");
    chk("R1 index after reset", a_pr_idx, x_idx);
    chk("R1 counter back to weak not taken", a_pr_t, 1'b0);
    step(1, 1, 32'h0000_0024, 0, 0, '0, "R1 select after reset");
    chk("R1 select history cleared", b_pr_idx, 10'h009);

    summary();
  end

endmodule